// File: doc/BRIEF.md
# SMBus Alert Request Responder

This block carries out the alert-request test of a bus test unit. A command front-end hands it a start strobe together with a response byte and a delay count. The delay count is measured in 10 ms ticks. Once the delay has run out, the block pulls an active-low alert line low. For as long as the test runs, it swaps the unit's own slave address for the SMBus Alert Response Address 0x0C.

The host is expected to read one byte from 0x0C. The block acknowledges that read and returns the programmed response byte. The upper seven bits of that byte are the address the host will take as the alerting device. After the byte has gone out, the block releases the alert line, restores the unit's own address and pulses `done`.

If the host does not read 0x0C within a timeout, the block abandons the test. It then releases the line, restores the address and pulses `err`. The timeout is a parameter counted in 10 ms ticks.

Top module: `smb_alert_responder`

## Requirements
- R1: After reset, `alert_n` is 1, `busy`, `done` and `err` are 0, and `active_addr` equals `own_addr`.
- R2: A `start` accepted while idle with `delay_n` = n makes `alert_n` fall right after the clock edge that samples the n-th `tick`. With n = 0 it falls right after the edge that samples `start`. `busy` is 1 from that same start edge onward.
- R3: `active_addr` is 7'h0C whenever `alert_n` is 0, and it equals `own_addr` whenever `alert_n` is 1.
- R4: While the alert is pending, an address hit with `addr_rw` = 1 (read) gets `addr_ack` = 1 in the same cycle. From the next cycle on, `rd_data` holds the full response byte latched at start: bits 7:1 are the alerting address and bit 0 is returned unchanged.
- R5: While the alert is pending, an address hit with `addr_rw` = 0 (write) gets `addr_ack` = 0 and leaves the test running with `alert_n` still low.
- R6: A `byte_sent` pulse after the acknowledged read raises `done` for exactly one cycle. In that same cycle `alert_n` is 1, `busy` is 0 and `active_addr` equals `own_addr`.
- R7: If no read arrives within TIMEOUT_TICKS ticks of the alert falling, `err` is 1 for one cycle right after the edge that samples the last of those ticks. In that cycle `alert_n` is 1 and `active_addr` equals `own_addr`.
- R8: A `start` that arrives while the block is busy has no effect. The running test keeps its response byte and its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle strobe that starts the test |
| resp_byte | input | 8 | Byte returned on the alert response read |
| delay_n | input | DLY_W | Delay before the alert, in ticks |
| tick | input | 1 | One-cycle pulse every 10 ms |
| own_addr | input | 7 | Unit's normal slave address |
| addr_hit | input | 1 | Slave interface saw its address (`active_addr`) |
| addr_rw | input | 1 | Direction bit of that address byte, 1 = read |
| byte_sent | input | 1 | Slave interface finished sending `rd_data` |
| alert_n | output | 1 | Active-low alert line |
| active_addr | output | 7 | Address the slave interface must match |
| addr_ack | output | 1 | Acknowledge decision for the current `addr_hit` |
| rd_data | output | 8 | Byte to send on a read |
| busy | output | 1 | A test is in progress |
| done | output | 1 | One-cycle pulse: response sent |
| err | output | 1 | One-cycle pulse: host never answered |

## Verification
The bench sweeps delays from zero upward and a spread of response bytes, and counts ticks to the exact edge where the alert falls. A design that is off by one in its countdown would raise the line a cycle early or late, and one that mishandles the zero-delay case would wait an extra tick. Each sweep injects a write to 0x0C and a stray start into the alert window. A design that acknowledged the write, or took the new start, would end the test early or return the wrong byte. Timeout runs check that the error fires on the last tick, not one tick too early or too late, and that the own address comes back in the same cycle.

// File: rtl/smb_alert_responder.sv
module smb_alert_responder #(
  parameter int          DLY_W          = 8,
  parameter int          TIMEOUT_TICKS  = 100,
  parameter logic [6:0]  ARA_ADDR       = 7'h0C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       resp_byte,
  input  logic [DLY_W-1:0] delay_n,
  input  logic             tick,
  input  logic [6:0]       own_addr,
  input  logic             addr_hit,
  input  logic             addr_rw,
  input  logic             byte_sent,
  output logic             alert_n,
  output logic [6:0]       active_addr,
  output logic             addr_ack,
  output logic [7:0]       rd_data,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam int TO_W = $clog2(TIMEOUT_TICKS + 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_ALERT, S_SEND} state_t;

  state_t           state;
  logic [DLY_W-1:0] dcnt;
  logic [TO_W-1:0]  tcnt;
  logic [7:0]       resp_q;

  wire in_test = (state == S_ALERT) || (state == S_SEND);

  assign alert_n     = ~in_test;
  assign active_addr = in_test ? ARA_ADDR : own_addr;
  assign busy        = (state != S_IDLE);
  assign rd_data     = (state == S_SEND) ? resp_q : 8'h00;

  always_comb begin
    case (state)
      S_ALERT: addr_ack = addr_rw;
      S_SEND:  addr_ack = 1'b0;
      default: addr_ack = 1'b1;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      dcnt   <= '0;
      tcnt   <= '0;
      resp_q <= '0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          resp_q <= resp_byte;
          dcnt   <= delay_n;
          tcnt   <= '0;
          state  <= (delay_n == '0) ? S_ALERT : S_WAIT;
        end
        S_WAIT: if (tick) begin
          if (dcnt == DLY_W'(1)) state <= S_ALERT;
          dcnt <= dcnt - DLY_W'(1);
        end
        S_ALERT: begin
          if (addr_hit && addr_rw) begin
            state <= S_SEND;
          end else if (tick) begin
            if (tcnt == TO_W'(TIMEOUT_TICKS - 1)) begin
              state <= S_IDLE;
              err   <= 1'b1;
            end
            tcnt <= tcnt + TO_W'(1);
          end
        end
        S_SEND: if (byte_sent) begin
          state <= S_IDLE;
          done  <= 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/smb_alert_responder_chk.sv
module smb_alert_responder_chk #(
  parameter logic [6:0] ARA = 7'h0C
) (
  input logic       clk,
  input logic       rst_n,
  input logic       alert_n,
  input logic [6:0] active_addr,
  input logic [6:0] own_addr,
  input logic       addr_hit,
  input logic       addr_rw,
  input logic       addr_ack,
  input logic       busy,
  input logic       done,
  input logic       err
);
  AST_ALERT_USES_ARA: assert property (@(posedge clk) disable iff (!rst_n)
    !alert_n |-> active_addr == ARA); // R3
  AST_IDLE_USES_OWN: assert property (@(posedge clk) disable iff (!rst_n)
    alert_n |-> active_addr == own_addr); // R3
  AST_WRITE_NACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!alert_n && addr_hit && !addr_rw) |-> !addr_ack); // R5
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (alert_n && !busy && !err)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_ERR_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (alert_n && active_addr == own_addr)); // R7
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err); // R7
endmodule

bind smb_alert_responder smb_alert_responder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .alert_n(alert_n), .active_addr(active_addr),
  .own_addr(own_addr), .addr_hit(addr_hit), .addr_rw(addr_rw),
  .addr_ack(addr_ack), .busy(busy), .done(done), .err(err)
);

// File: tb/smb_alert_responder_tb.sv
module smb_alert_responder_tb_top;
  localparam int CLK_P = 10;
  localparam int TO    = 5;
  localparam logic [6:0] OWN = 7'h30;

  logic clk = 0, rst_n = 0;
  logic start = 0, tick = 0, addr_hit = 0, addr_rw = 0, byte_sent = 0;
  logic [7:0] resp_byte = 0, delay_n = 0;
  logic [6:0] own_addr = OWN;
  logic alert_n, addr_ack, busy, done, err;
  logic [6:0] active_addr;
  logic [7:0] rd_data;
  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  smb_alert_responder #(.DLY_W(8), .TIMEOUT_TICKS(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .resp_byte(resp_byte),
    .delay_n(delay_n), .tick(tick), .own_addr(own_addr), .addr_hit(addr_hit),
    .addr_rw(addr_rw), .byte_sent(byte_sent), .alert_n(alert_n),
    .active_addr(active_addr), .addr_ack(addr_ack), .rd_data(rd_data),
    .busy(busy), .done(done), .err(err));

  task automatic chk(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic begin_test(input int d, input logic [7:0] r);
    start = 1; delay_n = 8'(d); resp_byte = r;
    step();
    start = 0; resp_byte = 8'hEE;
    for (int i = 0; i < d; i++) begin
      chk(alert_n == 1'b1, "R2 alert before delay", alert_n, 1);
      chk(active_addr == OWN, "R3 own addr in delay", active_addr, OWN);
      chk(busy == 1'b1, "R2 busy in delay", busy, 1);
      tick = 1; step(); tick = 0;
    end
    chk(alert_n == 1'b0, "R2 alert after delay", alert_n, 0);
    chk(active_addr == 7'h0C, "R3 ARA during alert", active_addr, 7'h0C);
  endtask

  task automatic run_read(input int d, input logic [7:0] r);
    begin_test(d, r);
    addr_hit = 1; addr_rw = 0; #1;
    chk(addr_ack == 1'b0, "R5 write NACK", addr_ack, 0);
    step(); addr_hit = 0;
    chk(alert_n == 1'b0, "R5 alert kept after write", alert_n, 0);
    start = 1; delay_n = 8'd3; resp_byte = ~r; step(); start = 0;
    chk(alert_n == 1'b0 && busy, "R8 start ignored", alert_n, 0);
    addr_hit = 1; addr_rw = 1; #1;
    chk(addr_ack == 1'b1, "R4 read ACK", addr_ack, 1);
    step(); addr_hit = 0; addr_rw = 0;
    chk(rd_data == r, "R4 response byte", rd_data, r);
    chk(alert_n == 1'b0, "R4 alert held while sending", alert_n, 0);
    byte_sent = 1; step(); byte_sent = 0;
    chk(done == 1'b1, "R6 done", done, 1);
    chk(alert_n == 1'b1 && !busy, "R6 released", alert_n, 1);
    chk(active_addr == OWN, "R6 own addr back", active_addr, OWN);
    step();
    chk(done == 1'b0, "R6 done one cycle", done, 0);
  endtask

  task automatic run_timeout(input int d);
    begin_test(d, 8'h5A);
    for (int i = 0; i < TO - 1; i++) begin
      tick = 1; step(); tick = 0;
      chk(alert_n == 1'b0 && !err, "R7 no early error", err, 0);
    end
    tick = 1; step(); tick = 0;
    chk(err == 1'b1, "R7 error on timeout", err, 1);
    chk(alert_n == 1'b1, "R7 alert released", alert_n, 1);
    chk(active_addr == OWN, "R7 own addr back", active_addr, OWN);
    step();
    chk(err == 1'b0, "R7 error one cycle", err, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(alert_n == 1'b1 && !busy && !done && !err, "R1 reset state", alert_n, 1);
    chk(active_addr == OWN, "R1 reset addr", active_addr, OWN);
    rst_n = 1;
    step();
    for (int d = 0; d < 4; d++)
      for (int k = 0; k < 8; k++)
        run_read(d, 8'((k * 37 + 5 + d * 64) & 8'hFF));
    for (int d = 0; d < 3; d++) run_timeout(d);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule